// File: doc/BRIEF.md
# Pipelined Horner Polynomial Evaluator

This block evaluates a fixed-degree polynomial at a stream of sample points. It is a one-dimensional chain of cells that all advance together and pass data only to the right. The cells come in pairs. The first cell of a pair multiplies the running value by the point. The second cell adds one coefficient. The running value starts as the highest-order coefficient, and the last pair adds the constant term. Each point travels through the chain in its own register path, so every pair multiplies by the point that belongs to the item it is working on. A new point can enter on every cycle.

All arithmetic is signed two's complement and wraps at the data width. Coefficients are written through a plain write port. A write applies only to points accepted on later cycles. Each coefficient follows its data item down the chain, so points already inside the chain keep the values they entered with.

Both streams use valid/ready. A beat transfers on a cycle where valid and ready are both high. The output holds its value and its valid while `res_ready` is low. The chain moves only when its last stage is empty or is being drained. The input ready reflects exactly that condition, so the whole chain stalls as one unit under back-pressure.

Top module: `horner_pipe`

## Requirements
- R1: After reset, `res_valid` is low and every coefficient is zero, so a point evaluated before any write yields 0.
- R2: For coefficients c[0..DEG] and a point x, the result is c[DEG]·x^DEG + … + c[1]·x + c[0]. It is computed in Horner order: multiply by x, then add the next lower coefficient, DEG times.
- R3: With `res_ready` held high, a point accepted in cycle n appears on `res_y` with `res_valid` high in cycle n+2·DEG. One point is accepted per cycle.
- R4: While `res_valid` is high and `res_ready` is low, `res_valid` stays high, `res_y` does not change, and `pt_ready` is low.
- R5: `pt_ready` is high whenever `res_valid` is low or `res_ready` is high.
- R6: A write with `cw_en` high to `cw_idx` = i (0 ≤ i ≤ DEG, where index i holds the coefficient of x^i) changes the coefficient used by points accepted on later cycles. A point accepted on the same cycle as the write, or earlier, uses the old value.
- R7: A write whose `cw_idx` is greater than DEG has no effect on any result.
- R8: Every product and every sum is truncated to its low DW bits and read as signed, so overflow wraps.
- R9: Results leave in the order their points were accepted. Cycles without an accepted point produce no output beat, and no output beat appears without an accepted point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_valid | input | 1 | Input point is valid |
| pt_ready | output | 1 | Chain can accept a point this cycle |
| pt_x | input | DW | Evaluation point, signed |
| res_valid | output | 1 | Result is valid |
| res_ready | input | 1 | Downstream accepts the result |
| res_y | output | DW | Polynomial value, signed, wrapped |
| cw_en | input | 1 | Coefficient write strobe |
| cw_idx | input | IW | Coefficient index (power of x) |
| cw_data | input | DW | Coefficient value, signed |

## Verification
The bench builds the block with its defaults, DEG = 3 and DW = 16. That gives a six-stage chain, short enough that a write can land while points sit in every pair. The index port is three bits wide, so indices 4 to 7 can be driven to test ignored writes. Sixteen bits lets moderate points and coefficients overflow, which exercises the wrap rule. Back-pressure patterns are applied while the chain is full, which shows that the whole chain freezes in place.

// File: rtl/horner_pkg.sv
package horner_pkg;
  // Stage index of the multiply cell of pair k (pairs numbered 1..deg)
  function automatic int mul_stage(input int k);
    return 2 * k - 2;
  endfunction

  // Number of coefficient delay registers feeding the adder of pair k
  function automatic int coef_delay(input int k);
    return 2 * k - 1;
  endfunction

  // Power of x whose coefficient pair k adds
  function automatic int coef_power(input int deg, input int k);
    return deg - k;
  endfunction
endpackage

// File: rtl/horner_mul_cell.sv
module horner_mul_cell #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          vin,
  input  logic [DW-1:0] xin,
  input  logic [DW-1:0] ain,
  output logic          vout,
  output logic [DW-1:0] xout,
  output logic [DW-1:0] pout
);
  logic signed [2*DW-1:0] full;
  assign full = $signed(ain) * $signed(xin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vout <= 1'b0;
      xout <= '0;
      pout <= '0;
    end else if (adv) begin
      vout <= vin;
      xout <= xin;
      pout <= full[DW-1:0];
    end
  end

  // R4: a stalled chain keeps every stage frozen
  a_r4_mul_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(vout) && $stable(pout) && $stable(xout));
  // R2: the point follows its item to the next pair
  a_r2_x_travels: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> xout == $past(xin));
endmodule

// File: rtl/horner_add_cell.sv
module horner_add_cell #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          vin,
  input  logic [DW-1:0] xin,
  input  logic [DW-1:0] pin,
  input  logic [DW-1:0] cin,
  output logic          vout,
  output logic [DW-1:0] xout,
  output logic [DW-1:0] sout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vout <= 1'b0;
      xout <= '0;
      sout <= '0;
    end else if (adv) begin
      vout <= vin;
      xout <= xin;
      sout <= pin + cin;
    end
  end

  // R9: a valid item moves on, a bubble stays a bubble
  a_r9_item_moves: assert property (@(posedge clk) disable iff (!rst_n)
    adv && vin |=> vout);
  a_r9_bubble_moves: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !vin |=> !vout);
endmodule

// File: rtl/horner_coef_bank.sv
module horner_coef_bank #(
  parameter int DEG = 3,
  parameter int DW  = 16,
  parameter int IW  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IW-1:0]          idx,
  input  logic [DW-1:0]          data,
  output logic [(DEG+1)*DW-1:0]  coef_flat
);
  logic [DW-1:0] bank [0:DEG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j <= DEG; j++) bank[j] <= '0;
    end else if (we) begin
      for (int j = 0; j <= DEG; j++)
        if (int'(idx) == j) bank[j] <= data;
    end
  end

  for (genvar j = 0; j <= DEG; j++) begin : g_flat
    assign coef_flat[j*DW +: DW] = bank[j];
  end

  // R7: an out-of-range index leaves the bank unchanged
  a_r7_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    we && (int'(idx) > DEG) |=> $stable(coef_flat));
  // R6: without a write the bank holds
  a_r6_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(coef_flat));
endmodule

// File: rtl/horner_pipe.sv
module horner_pipe #(
  parameter int DEG = 3,
  parameter int DW  = 16,
  parameter int IW  = $clog2(DEG + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pt_valid,
  output logic          pt_ready,
  input  logic [DW-1:0] pt_x,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_y,
  input  logic          cw_en,
  input  logic [IW-1:0] cw_idx,
  input  logic [DW-1:0] cw_data
);
  import horner_pkg::*;

  localparam int NST = 2 * DEG;

  logic                  adv;
  logic [(DEG+1)*DW-1:0] coef_flat;
  logic                  nv [0:NST];
  logic [DW-1:0]         nx [0:NST];
  logic [DW-1:0]         nd [0:NST];

  assign adv      = !res_valid || res_ready;
  assign pt_ready = adv;

  horner_coef_bank #(.DEG(DEG), .DW(DW), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cw_en), .idx(cw_idx), .data(cw_data),
    .coef_flat(coef_flat)
  );

  // Entry: the running value starts as the highest-order coefficient
  assign nv[0] = pt_valid;
  assign nx[0] = pt_x;
  assign nd[0] = coef_flat[DEG*DW +: DW];

  for (genvar k = 1; k <= DEG; k++) begin : g_pair
    localparam int MS = mul_stage(k);
    localparam int DL = coef_delay(k);
    localparam int CP = coef_power(DEG, k);

    // Coefficient snapshot travels alongside its data item
    logic [DW-1:0] cdly [0:DL-1];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DL; i++) cdly[i] <= '0;
      end else if (adv) begin
        cdly[0] <= coef_flat[CP*DW +: DW];
        for (int i = 1; i < DL; i++) cdly[i] <= cdly[i-1];
      end
    end

    horner_mul_cell #(.DW(DW)) u_mul (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .vin(nv[MS]), .xin(nx[MS]), .ain(nd[MS]),
      .vout(nv[MS+1]), .xout(nx[MS+1]), .pout(nd[MS+1])
    );

    horner_add_cell #(.DW(DW)) u_add (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .vin(nv[MS+1]), .xin(nx[MS+1]), .pin(nd[MS+1]), .cin(cdly[DL-1]),
      .vout(nv[MS+2]), .xout(nx[MS+2]), .sout(nd[MS+2])
    );
  end

  assign res_valid = nv[NST];
  assign res_y     = nd[NST];

  // R4: a result under back-pressure is held unchanged
  a_r4_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_y));
  // R4: no point is taken while the output is blocked
  a_r4_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !pt_ready);
  // R1: reset empties the chain
  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !res_valid);
endmodule

// File: tb/horner_pipe_bench.sv
module horner_pipe_bench;
  localparam int DEG = 3;
  localparam int DW  = 16;
  localparam int IW  = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic pt_valid = 0, res_ready = 1, cw_en = 0;
  logic [DW-1:0] pt_x = '0, cw_data = '0;
  logic [IW-1:0] cw_idx = '0;
  logic pt_ready, res_valid;
  logic [DW-1:0] res_y;

  always #5 clk = ~clk;

  horner_pipe u_horner_pipe (
    .clk(clk), .rst_n(rst_n), .pt_valid(pt_valid), .pt_ready(pt_ready),
    .pt_x(pt_x), .res_valid(res_valid), .res_ready(res_ready), .res_y(res_y),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, lat_chk = 0;
  logic signed [DW-1:0] mc [0:DEG];
  logic [DW-1:0] exp_q [$];
  string tag_q [$];
  int acc_q [$];
  bit lat_q [$];
  bit prev_stall = 0;
  logic [DW-1:0] prev_y = '0;

  localparam logic signed [DW-1:0] CTAB [0:3] = '{16'sd7, -16'sd3, 16'sd2, 16'sd1};
  localparam logic signed [DW-1:0] XTAB [0:9] =
    '{16'sd0, 16'sd1, -16'sd1, 16'sd2, -16'sd2, 16'sd3, 16'sd10, -16'sd7, 16'sd25, 16'sd5};

  function automatic logic [DW-1:0] ref_eval(input logic [DW-1:0] x);
    logic signed [DW-1:0] acc;
    longint t;
    acc = mc[DEG];
    for (int k = DEG - 1; k >= 0; k--) begin
      t = longint'(acc) * longint'($signed(x));
      acc = t[DW-1:0];
      t = longint'(acc) + longint'(mc[k]);
      acc = t[DW-1:0];
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit iv, input logic [DW-1:0] x, input bit ordy,
                      input bit we, input logic [IW-1:0] idx,
                      input logic [DW-1:0] data, input string tag);
    bit stall_now;
    pt_valid = iv; pt_x = x; res_ready = ordy;
    cw_en = we; cw_idx = idx; cw_data = data;
    #1;
    if (prev_stall) begin
      check(res_valid == 1'b1, "R4", "valid held", res_valid, 1);
      check(res_y == prev_y, "R4", "result held", $signed(res_y), $signed(prev_y));
    end
    if (res_valid && !res_ready)
      check(pt_ready == 1'b0, "R4", "ready low when blocked", pt_ready, 0);
    if (!res_valid || res_ready)
      check(pt_ready == 1'b1, "R5", "ready high", pt_ready, 1);
    if (res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected output", $signed(res_y), 0);
      end else begin
        string t;
        int a;
        bit l;
        logic [DW-1:0] e;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        a = acc_q.pop_front(); l = lat_q.pop_front();
        check(res_y == e, t, "result", $signed(res_y), $signed(e));
        if (l) check(cyc - a == 2 * DEG, "R3", "latency", cyc - a, 2 * DEG);
      end
    end
    if (iv && pt_ready) begin
      exp_q.push_back(ref_eval(x)); tag_q.push_back(tag);
      acc_q.push_back(cyc); lat_q.push_back(lat_chk);
    end
    if (we && int'(idx) <= DEG) mc[idx] = data;
    stall_now = res_valid && !res_ready;
    prev_stall = stall_now; prev_y = res_y;
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 1, 0, '0, '0, "R9");
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j <= DEG; j++) mc[j] = '0;
    repeat (3) @(negedge clk);
    #1;
    check(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(res_valid == 1'b0, "R1", "valid after reset", res_valid, 0);
    check(pt_ready == 1'b1, "R5", "ready after reset", pt_ready, 1);
    @(negedge clk);

    // R1: zero coefficients give zero
    step(1, 16'sd5, 1, 0, '0, '0, "R1");
    step(1, -16'sd9, 1, 0, '0, '0, "R1");
    idle(8);

    // R2/R3: table walk, back to back
    for (int j = 0; j <= DEG; j++) step(0, '0, 1, 1, IW'(j), CTAB[j], "R2");
    lat_chk = 1;
    for (int i = 0; i < 10; i++) step(1, XTAB[i], 1, 0, '0, '0, "R2");
    idle(8);
    lat_chk = 0;

    // R8: overflow wraps
    step(0, '0, 1, 1, 3'd3, 16'sd12000, "R8");
    step(0, '0, 1, 1, 3'd2, -16'sd9000, "R8");
    step(0, '0, 1, 1, 3'd1, 16'sd30000, "R8");
    step(0, '0, 1, 1, 3'd0, 16'sd7, "R8");
    step(1, 16'sd250, 1, 0, '0, '0, "R8");
    step(1, -16'sd311, 1, 0, '0, '0, "R8");
    step(1, 16'sd32767, 1, 0, '0, '0, "R8");
    idle(8);

    // R6: writes while points are in flight
    for (int i = 1; i <= 10; i++) begin
      if (i == 3) step(1, DW'(i), 1, 1, 3'd0, 16'sd100, "R6");
      else if (i == 5) step(1, DW'(i), 1, 1, 3'd3, -16'sd2, "R6");
      else if (i == 7) step(1, DW'(i), 1, 1, 3'd1, 16'sd11, "R6");
      else step(1, DW'(i), 1, 0, '0, '0, "R6");
    end
    idle(8);

    // R7: out-of-range indices ignored
    step(0, '0, 1, 1, 3'd4, 16'sd1234, "R7");
    step(0, '0, 1, 1, 3'd7, -16'sd555, "R7");
    step(1, 16'sd3, 1, 1, 3'd5, 16'sd999, "R7");
    step(1, -16'sd4, 1, 0, '0, '0, "R7");
    idle(8);

    // R9: bubbles keep order and spacing
    lat_chk = 1;
    step(1, 16'sd2, 1, 0, '0, '0, "R9");
    step(0, '0, 1, 0, '0, '0, "R9");
    step(0, '0, 1, 0, '0, '0, "R9");
    step(1, 16'sd6, 1, 0, '0, '0, "R9");
    step(1, -16'sd6, 1, 0, '0, '0, "R9");
    step(0, '0, 1, 0, '0, '0, "R9");
    step(1, 16'sd9, 1, 0, '0, '0, "R9");
    idle(8);
    lat_chk = 0;

    // R4: back-pressure while the chain is full
    for (int i = 0; i < 24; i++) begin
      bit r;
      r = (i < 8) || (i % 3 == 0);
      step(1, DW'(i * 5 - 40), r, 0, '0, '0, "R4");
    end
    step(0, '0, 0, 0, '0, '0, "R4");
    step(0, '0, 0, 0, '0, '0, "R4");
    idle(14);

    check(exp_q.size() == 0, "R9", "outputs missing", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule